// File: doc/BRIEF.md
# Branch Target CAM with History Override

This block sits beside a 2-bit history predictor in an instruction fetch unit. Each cycle it searches a fully associative table of branch addresses for the current fetch address. It then merges the search result with the taken/not-taken verdict of the history predictor into one overall guess. A match always yields a taken guess together with the stored target, in the same cycle. Without a match the history verdict passes through unchanged, and the block supplies no target.

The block reports which source produced a taken guess. A taken guess from a table match needs no redirect bubble. A taken guess from the history counter costs the fetch unit at least one extra cycle, because the target must come from elsewhere.

Resolved branches come back on an update port. A taken branch that is not yet in the table takes an entry, chosen in round-robin order. A not-taken branch that is in the table frees its entry.

Top module: `jump_target_cam`

## Requirements
- R1: Each cycle `fetch_addr` is compared against the full stored branch address of every valid entry (`ENTRIES` entries, default 64). `cam_hit` is high, combinationally, exactly when a valid entry matches.
- R2: On a hit, `pred_target` carries that entry's stored target and `pred_tgt_vld` is high in the same cycle.
- R3: On a hit, `pred_taken` is 1 and `pred_src` is 2'b01 (taken by table match, no redirect penalty), whatever `dir_taken` is.
- R4: On a miss, `pred_taken` equals `dir_taken`. `pred_src` is 2'b10 (taken by counter, redirect penalty) when `dir_taken` is 1, and 2'b00 (not taken) when it is 0.
- R5: On a miss, `pred_tgt_vld` is 0 and `pred_target` is all zeros.
- R6: An update with `upd_taken`=1 whose `upd_pc` is not held in the table writes `upd_pc` and `upd_target` into the entry under a round-robin pointer. It overwrites that entry even if it is valid. The pointer then advances by one and wraps from `ENTRIES`-1 to 0. After reset the first allocation uses entry 0.
- R7: An update with `upd_taken`=1 whose `upd_pc` is already held replaces that entry's target. The pointer does not move and no second entry is made.
- R8: An update with `upd_taken`=0 whose `upd_pc` is held clears that entry. An update with `upd_taken`=0 whose `upd_pc` is not held changes nothing. The pointer does not move in either case.
- R9: Asserting `rst_n` low (asynchronous, active low) clears every valid bit and returns the pointer to 0.
- R10: An update becomes visible to lookups from the cycle after its clock edge. A lookup in the same cycle as the update sees the previous contents.
- R11: No branch address is ever held in more than one valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | input | ADDR_W | Address searched this cycle |
| dir_taken | input | 1 | Verdict of the 2-bit history predictor |
| upd_valid | input | 1 | Resolved-branch update present |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_target | input | TGT_W | Target of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| cam_hit | output | 1 | Fetch address found in the table |
| pred_taken | output | 1 | Overall guess |
| pred_target | output | TGT_W | Stored target on a hit, zero otherwise |
| pred_tgt_vld | output | 1 | `pred_target` is usable |
| pred_src | output | 2 | 00 not taken, 01 taken by match, 10 taken by counter |

## Verification
Every lookup output is combinational in `fetch_addr`, `dir_taken` and the stored contents. The bench therefore drives a vector after a falling edge and compares the outputs 2 ns later, within the same cycle. An update is driven after a falling edge, is committed at the following rising edge, and is applied to the bench's model at that same edge. Sweeps start only from the next falling edge. The same-cycle case is checked on both sides of the edge: a miss before the edge and a hit after it.

// File: rtl/jtc_pkg.sv
package jtc_pkg;

   typedef enum logic [1:0] {
      SRC_NONE = 2'b00,
      SRC_CAM  = 2'b01,
      SRC_CTR  = 2'b10
   } guess_src_e;

endpackage

// File: rtl/jtc_cam_array.sv
module jtc_cam_array #(
   parameter int ENTRIES   = 64,
   parameter int ADDR_W    = 32,
   parameter int TGT_W     = 32,
   parameter int MUX_STYLE = 0,
   localparam int IDX_W    = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  lk_addr,
   output logic               lk_hit,
   output logic [TGT_W-1:0]   lk_target,
   output logic [ENTRIES-1:0] lk_match,
   input  logic [ADDR_W-1:0]  up_addr,
   output logic               up_hit,
   output logic [IDX_W-1:0]   up_idx,
   input  logic               alloc_en,
   input  logic [IDX_W-1:0]   alloc_idx,
   input  logic               fix_en,
   input  logic               fix_clr,
   input  logic [IDX_W-1:0]   fix_idx,
   input  logic [TGT_W-1:0]   wr_tgt,
   output logic [ENTRIES-1:0] vld_vec
);

   logic [TGT_W-1:0]   tgt_a [ENTRIES];
   logic [ENTRIES-1:0] up_match;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic              vld_r;
      logic [ADDR_W-1:0] tag_r;
      logic [TGT_W-1:0]  tgt_r;
      logic              sel_alloc;
      logic              sel_fix;

      assign sel_alloc = alloc_en && (alloc_idx == IDX_W'(e));
      assign sel_fix   = fix_en && (fix_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_r <= 1'b0;
         end else if (sel_alloc) begin
            vld_r <= 1'b1;
         end else if (sel_fix && fix_clr) begin
            vld_r <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (sel_alloc) begin
            tag_r <= up_addr;
         end
         if (sel_alloc || (sel_fix && !fix_clr)) begin
            tgt_r <= wr_tgt;
         end
      end

      assign vld_vec[e]  = vld_r;
      assign tgt_a[e]    = tgt_r;
      assign lk_match[e] = vld_r && (tag_r == lk_addr);
      assign up_match[e] = vld_r && (tag_r == up_addr);
   end

   assign lk_hit = |lk_match;
   assign up_hit = |up_match;

   always_comb begin
      up_idx = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (up_match[e]) begin
            up_idx = IDX_W'(e);
         end
      end
   end

   if (MUX_STYLE == 0) begin : g_andor
      always_comb begin
         lk_target = '0;
         for (int e = 0; e < ENTRIES; e++) begin
            lk_target = lk_target | ({TGT_W{lk_match[e]}} & tgt_a[e]);
         end
      end
   end else begin : g_prio
      always_comb begin
         lk_target = '0;
         for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (lk_match[e]) begin
               lk_target = tgt_a[e];
            end
         end
      end
   end

endmodule

// File: rtl/jtc_victim_ptr.sv
module jtc_victim_ptr #(
   parameter int ENTRIES = 64,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam bit POW2   = ((ENTRIES & (ENTRIES - 1)) == 0)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);

   logic [IDX_W-1:0] nxt;

   if (POW2) begin : g_wrap_free
      assign nxt = ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign nxt = (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (adv) begin
         ptr <= nxt;
      end
   end

endmodule

// File: rtl/jtc_combine.sv
module jtc_combine
   import jtc_pkg::*;
#(
   parameter int TGT_W = 32
) (
   input  logic             cam_hit,
   input  logic [TGT_W-1:0] cam_target,
   input  logic             dir_taken,
   output logic             guess_taken,
   output logic [TGT_W-1:0] guess_target,
   output logic             guess_tgt_vld,
   output guess_src_e       guess_src
);

   always_comb begin
      if (cam_hit) begin
         guess_taken   = 1'b1;
         guess_target  = cam_target;
         guess_tgt_vld = 1'b1;
         guess_src     = SRC_CAM;
      end else begin
         guess_taken   = dir_taken;
         guess_target  = '0;
         guess_tgt_vld = 1'b0;
         guess_src     = dir_taken ? SRC_CTR : SRC_NONE;
      end
   end

endmodule

// File: rtl/jump_target_cam.sv
module jump_target_cam
   import jtc_pkg::*;
#(
   parameter int ENTRIES   = 64,
   parameter int ADDR_W    = 32,
   parameter int TGT_W     = 32,
   parameter int MUX_STYLE = 0,
   localparam int IDX_W    = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              dir_taken,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_pc,
   input  logic [TGT_W-1:0]  upd_target,
   input  logic              upd_taken,
   output logic              cam_hit,
   output logic              pred_taken,
   output logic [TGT_W-1:0]  pred_target,
   output logic              pred_tgt_vld,
   output logic [1:0]        pred_src
);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("jump_target_cam: ENTRIES must be at least 2");
   end
   if (ADDR_W < 1 || TGT_W < 1) begin : g_bad_width
      $error("jump_target_cam: address and target widths must be positive");
   end
   if (MUX_STYLE != 0 && MUX_STYLE != 1) begin : g_bad_mux
      $error("jump_target_cam: MUX_STYLE must be 0 or 1");
   end

   logic [TGT_W-1:0]   cam_target;
   logic [ENTRIES-1:0] lk_match;
   logic [ENTRIES-1:0] vld_vec;
   logic               up_hit;
   logic [IDX_W-1:0]   up_idx;
   logic [IDX_W-1:0]   victim;
   logic               alloc_en;
   logic               fix_en;
   guess_src_e         src_e;

   assign alloc_en = upd_valid && upd_taken && !up_hit;
   assign fix_en   = upd_valid && up_hit;

   jtc_cam_array #(
      .ENTRIES  (ENTRIES),
      .ADDR_W   (ADDR_W),
      .TGT_W    (TGT_W),
      .MUX_STYLE(MUX_STYLE)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_addr  (fetch_addr),
      .lk_hit   (cam_hit),
      .lk_target(cam_target),
      .lk_match (lk_match),
      .up_addr  (upd_pc),
      .up_hit   (up_hit),
      .up_idx   (up_idx),
      .alloc_en (alloc_en),
      .alloc_idx(victim),
      .fix_en   (fix_en),
      .fix_clr  (!upd_taken),
      .fix_idx  (up_idx),
      .wr_tgt   (upd_target),
      .vld_vec  (vld_vec)
   );

   jtc_victim_ptr #(
      .ENTRIES(ENTRIES)
   ) u_victim (
      .clk  (clk),
      .rst_n(rst_n),
      .adv  (alloc_en),
      .ptr  (victim)
   );

   jtc_combine #(
      .TGT_W(TGT_W)
   ) u_combine (
      .cam_hit      (cam_hit),
      .cam_target   (cam_target),
      .dir_taken    (dir_taken),
      .guess_taken  (pred_taken),
      .guess_target (pred_target),
      .guess_tgt_vld(pred_tgt_vld),
      .guess_src    (src_e)
   );

   assign pred_src = src_e;

endmodule

// File: rtl/jtc_checker.sv
module jtc_checker #(
   parameter int ENTRIES = 64,
   parameter int TGT_W   = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               dir_taken,
   input logic               upd_valid,
   input logic               upd_taken,
   input logic               cam_hit,
   input logic               pred_taken,
   input logic [TGT_W-1:0]   pred_target,
   input logic               pred_tgt_vld,
   input logic [1:0]         pred_src,
   input logic               up_hit,
   input logic [ENTRIES-1:0] lk_match,
   input logic [ENTRIES-1:0] vld_vec,
   input logic [IDX_W-1:0]   victim
);

   // R3
   hit_forces_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cam_hit |-> (pred_taken && pred_src == 2'b01 && pred_tgt_vld));

   // R4
   miss_follows_counter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cam_hit |-> (pred_taken == dir_taken &&
                    pred_src == (dir_taken ? 2'b10 : 2'b00)));

   // R5
   miss_no_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cam_hit |-> (!pred_tgt_vld && pred_target == '0));

   // R11
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));

   // R6
   alloc_fills_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken && !up_hit) |=> vld_vec[$past(victim)]);

   // R6
   alloc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken && !up_hit) |=>
         (victim == (($past(victim) == IDX_W'(ENTRIES - 1)) ? '0 : $past(victim) + 1'b1)));

   // R8
   invalidate_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken && up_hit) |=>
         ($countones(vld_vec) == $countones($past(vld_vec)) - 1 && $stable(victim)));

   // R9
   reset_clears_chk: assert property (@(posedge clk)
      !rst_n |=> (vld_vec == '0 && victim == '0));

endmodule

bind jump_target_cam jtc_checker #(
   .ENTRIES(ENTRIES),
   .TGT_W  (TGT_W)
) u_jtc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dir_taken   (dir_taken),
   .upd_valid   (upd_valid),
   .upd_taken   (upd_taken),
   .cam_hit     (cam_hit),
   .pred_taken  (pred_taken),
   .pred_target (pred_target),
   .pred_tgt_vld(pred_tgt_vld),
   .pred_src    (pred_src),
   .up_hit      (up_hit),
   .lk_match    (lk_match),
   .vld_vec     (vld_vec),
   .victim      (victim)
);

// File: tb/jump_target_cam_bench.sv
module jump_target_cam_bench;

   localparam int N  = 4;
   localparam int AW = 8;
   localparam int TW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] fetch_addr = '0;
   logic          dir_taken = 1'b0;
   logic          upd_valid = 1'b0;
   logic [AW-1:0] upd_pc = '0;
   logic [TW-1:0] upd_target = '0;
   logic          upd_taken = 1'b0;
   logic          cam_hit;
   logic          pred_taken;
   logic [TW-1:0] pred_target;
   logic          pred_tgt_vld;
   logic [1:0]    pred_src;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic          m_vld [N];
   logic [AW-1:0] m_tag [N];
   logic [TW-1:0] m_tgt [N];
   int            m_ptr;

   always #5 clk = ~clk;

   jump_target_cam #(
      .ENTRIES(N), .ADDR_W(AW), .TGT_W(TW), .MUX_STYLE(0)
   ) u_jump_target_cam (
      .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .dir_taken(dir_taken),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
      .upd_taken(upd_taken), .cam_hit(cam_hit), .pred_taken(pred_taken),
      .pred_target(pred_target), .pred_tgt_vld(pred_tgt_vld), .pred_src(pred_src)
   );

   task automatic model_reset();
      for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
      m_ptr = 0;
   endtask

   function automatic logic [12:0] expect_out(logic [AW-1:0] a, logic d);
      for (int i = 0; i < N; i++)
         if (m_vld[i] && m_tag[i] == a) return {1'b1, 1'b1, 1'b1, 2'b01, m_tgt[i]};
      return {d, 1'b0, 1'b0, (d ? 2'b10 : 2'b00), {TW{1'b0}}};
   endfunction

   task automatic check(string tag, logic [12:0] exp);
      logic [12:0] act;
      act = {pred_taken, cam_hit, pred_tgt_vld, pred_src, pred_target};
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s addr=%h dir=%b actual=%h expected=%h",
                  tag, fetch_addr, dir_taken, act, exp);
      end
   endtask

   // full sweep of fetch address and counter verdict; tag names the phase
   task automatic sweep(string phase);
      for (int a = 0; a < (1 << AW); a++) begin
         for (int d = 0; d < 2; d++) begin
            logic [12:0] e;
            @(negedge clk);
            fetch_addr = AW'(a);
            dir_taken  = d[0];
            #2;
            e = expect_out(AW'(a), d[0]);
            if (e[11]) check({phase, " R1 R2 R3"}, e);
            else       check({phase, " R1 R4 R5"}, e);
         end
      end
   endtask

   task automatic model_update(logic [AW-1:0] pc, logic [TW-1:0] t, logic tk);
      int j;
      j = -1;
      for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == pc) j = i;
      if (tk) begin
         if (j >= 0) m_tgt[j] = t;
         else begin
            m_vld[m_ptr] = 1'b1; m_tag[m_ptr] = pc; m_tgt[m_ptr] = t;
            m_ptr = (m_ptr + 1) % N;
         end
      end else if (j >= 0) begin
         m_vld[j] = 1'b0;
      end
   endtask

   task automatic update(logic [AW-1:0] pc, logic [TW-1:0] t, logic tk);
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = pc; upd_target = t; upd_taken = tk;
      @(posedge clk);
      model_update(pc, t, tk);
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9 reset state at the ports
      fetch_addr = 8'h00; dir_taken = 1'b1; #2;
      check("R9 reset", {1'b1, 1'b0, 1'b0, 2'b10, 8'h00});
      rst_n = 1'b1;
      sweep("R9 empty");

      // R6 allocation into entries 0..2
      update(8'h10, 8'hA1, 1'b1);
      update(8'h24, 8'hB2, 1'b1);
      update(8'hFF, 8'hC3, 1'b1);
      sweep("R6 fill");

      // R7 retarget existing entry, no second copy
      update(8'h24, 8'h5D, 1'b1);
      sweep("R7 R11 retarget");

      // R8 invalidate held, then not-taken miss is a no-op
      update(8'h10, 8'h00, 1'b0);
      update(8'h77, 8'h00, 1'b0);
      sweep("R8 clear");

      // R6 wrap: overwrites valid entries in round-robin order
      update(8'h31, 8'h01, 1'b1);
      update(8'h32, 8'h02, 1'b1);
      update(8'h33, 8'h03, 1'b1);
      update(8'h34, 8'h04, 1'b1);
      sweep("R6 wrap");

      // R10 same-cycle update and lookup
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = 8'h9C; upd_target = 8'hE7; upd_taken = 1'b1;
      fetch_addr = 8'h9C; dir_taken = 1'b0; #2;
      check("R10 before edge", expect_out(8'h9C, 1'b0));
      @(posedge clk);
      model_update(8'h9C, 8'hE7, 1'b1);
      @(negedge clk);
      upd_valid = 1'b0; #2;
      check("R10 after edge", {1'b1, 1'b1, 1'b1, 2'b01, 8'hE7});

      // R9 reset mid-run, then first allocation goes to entry 0
      @(negedge clk);
      rst_n = 1'b0; #2;
      model_reset();
      fetch_addr = 8'h9C; dir_taken = 1'b0; #1;
      check("R9 async clear", {1'b0, 1'b0, 1'b0, 2'b00, 8'h00});
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 5; k++) update(AW'(8'h60 + k), TW'(8'h80 + k), 1'b1);
      sweep("R9 R6 restart");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule